// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers interrupt requests from a parameterised group of hardware sources and from eight sources that software raises and drops through register writes. Every source carries a programmable 4-bit level. The block picks the most urgent pending source and raises a single request line toward the processor only when that source's level is strictly above the level of the code now running. The vector that goes with the request is the source's own index.

Taking an interrupt saves the running level on a 16-entry hardware stack and makes the level of the taken source the running level. An end-of-interrupt write restores the saved level. This lets more urgent handlers nest over less urgent ones without software bookkeeping. Software can also write the running level directly, for example to lift a task to a ceiling level while it holds a shared resource.

The acknowledge can come from a dedicated input pin. In the software vector mode it comes instead from a read of the vector register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irqOut is 0, the running level (address 1) reads 0, the mode register (address 0) reads 1 (hardware acknowledge mode), every level register reads 0 and the status register (address 5) reads 0.
- R2: The level of source i is held in bits [3:0] of address 8+i. It accepts all 16 values and reads back what was written.
- R3: irqOut is 1 only when the best pending source has a level strictly greater than the running level. vecOut then equals that source's index: software sources are 0..7 and hardware input j is 8+j.
- R4: Among pending sources of equal top level, the lowest index wins.
- R5: A hardware request that first rises before clock edge k raises irqOut right after edge k+2 and not earlier (three register stages).
- R6: In hardware mode, ackIn high while irqOut is 1 pushes the running level, loads the presented source's level as the running level, and drops irqOut on that same edge unless a more urgent source is waiting.
- R7: Any write to address 3 (end of interrupt) pops the stack into the running level.
- R8: A write to address 1 sets the running level from bits [3:0]. Sources at or below it are held off, and a lower write lets them through again.
- R9: A write to address 4 sets software sources from bits [7:0] and then clears them from bits [15:8] (clear wins). A read of address 4 returns the pending software sources in bits [7:0].
- R10: With mode bit 0 cleared (software mode), a read of address 2 while irqOut is 1 returns the vector in bits [8:0] with bit 15 set, and acknowledges exactly as in R6. In hardware mode the same read has no side effect.
- R11: The stack holds 16 levels. A push when it is full loses the value and sets status bit 0. A pop when it is empty sets status bit 1 and leaves the running level unchanged. Both bits stay set until a 1 is written to them at address 5.
- R12: ackIn is ignored while irqOut is 0, and it is ignored in software mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwReq | input | NUM_HW | Level-sensitive hardware requests |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid in the same cycle as the address |
| ackIn | input | 1 | Hardware acknowledge |
| irqOut | output | 1 | Interrupt request to the processor |
| vecOut | output | VEC_W | Vector of the presented source |

## Verification
The bench targets equal-level and equal-to-running-level requests. A design using >= instead of > would raise an interrupt it must hold off, and a reversed scan would pick the wrong tied source. It counts the exact edge at which a hardware request appears, so a missing or extra pipeline stage shows up as an early or late irqOut. It drives seventeen nested acknowledges and seventeen restores, so a stack that wraps, loses its flags or changes the level on an empty pop returns wrong levels or status. It also sends stray acknowledges, and sends vector reads in both modes, so that a spurious push shows up in the running level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int PRIO_W = 4;
  localparam int NUM_SW = 8;
  localparam int DATA_W = 16;

  // register word addresses
  localparam int REG_CTL = 0;
  localparam int REG_CUR = 1;
  localparam int REG_VEC = 2;
  localparam int REG_EOI = 3;
  localparam int REG_SWR = 4;
  localparam int REG_STS = 5;
  localparam int REG_PRIO_BASE = 8;

  typedef struct packed {
    logic push;    // acknowledge: save running level, load new one
    logic pop;     // end of interrupt: restore saved level
    logic wrCur;   // direct write of running level
    logic wrPrio;  // write into a source level register
    logic wrSw;    // software source set/clear
    logic wrSts;   // sticky flag clear
    logic wrCtl;   // mode register write
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_prio_lifo.sv
module irq_prio_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  input  logic         clrOvf,
  input  logic         clrUnf,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign top   = mem[PTR_W'(cnt - CNT_W'(1))];

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PTR_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push && !full)       cnt <= cnt + CNT_W'(1);
      else if (pop && !empty)  cnt <= cnt - CNT_W'(1);
      ovf <= (ovf & ~clrOvf) | (push & full);
      unf <= (unf & ~clrUnf) | (pop & ~push & empty);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |=> ovf);
  assert_pop_depth_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && !empty) |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC   = 24,
  parameter int ADDR_W = 5
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ackIn,
  input  logic              irqOut,
  input  logic              hwVecMode,
  output ctrlStrobes_t      strobes
);
  logic ackHw, ackSw, isPrioAddr;

  assign ackHw      = hwVecMode && ackIn && irqOut;
  assign ackSw      = !hwVecMode && regRdEn && (int'(regAddr) == REG_VEC) && irqOut;
  assign isPrioAddr = (int'(regAddr) >= REG_PRIO_BASE) &&
                      (int'(regAddr) <  REG_PRIO_BASE + NSRC);

  always_comb begin
    strobes.push   = ackHw || ackSw;
    strobes.pop    = regWrEn && (int'(regAddr) == REG_EOI) && !strobes.push;
    strobes.wrCur  = regWrEn && (int'(regAddr) == REG_CUR) && !strobes.push;
    strobes.wrPrio = regWrEn && isPrioAddr;
    strobes.wrSw   = regWrEn && (int'(regAddr) == REG_SWR);
    strobes.wrSts  = regWrEn && (int'(regAddr) == REG_STS);
    strobes.wrCtl  = regWrEn && (int'(regAddr) == REG_CTL);
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_HW     = 16,
  parameter int VEC_W      = 9,
  parameter int LIFO_DEPTH = 16,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [NUM_HW-1:0] hwReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              hwVecMode,
  output logic              irqOut,
  output logic [VEC_W-1:0]  vecOut
);
  localparam int NSRC  = NUM_SW + NUM_HW;
  localparam int IDX_W = $clog2(NSRC);

  logic [PRIO_W-1:0] prioTab [NSRC];
  logic [NUM_SW-1:0] swPend;
  logic [NUM_HW-1:0] reqQ;
  logic [NSRC-1:0]   pendAll;

  logic              arbValid;
  logic [PRIO_W-1:0] arbPrio;
  logic [IDX_W-1:0]  arbIdx;
  logic              winValid;
  logic [PRIO_W-1:0] winPrio;
  logic [IDX_W-1:0]  winIdx;

  logic [PRIO_W-1:0] irqPrio;
  logic [PRIO_W-1:0] curPrio, curPrioNext;
  logic [PRIO_W-1:0] lifoTop;
  logic              lifoEmpty, ovfFlag, unfFlag;

  // level registers, one per source
  for (genvar g = 0; g < NSRC; g++) begin : gPrio
    always_ff @(posedge clk) begin
      if (!rstN) prioTab[g] <= '0;
      else if (strobes.wrPrio && int'(regAddr) == REG_PRIO_BASE + g)
        prioTab[g] <= regWrData[PRIO_W-1:0];
    end
  end

  // stage 1: capture requests; software sources share the stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ      <= '0;
      swPend    <= '0;
      hwVecMode <= 1'b1;
    end else begin
      reqQ <= hwReq;
      if (strobes.wrSw)
        swPend <= (swPend | regWrData[NUM_SW-1:0]) & ~regWrData[2*NUM_SW-1:NUM_SW];
      if (strobes.wrCtl) hwVecMode <= regWrData[0];
    end
  end

  assign pendAll = {reqQ, swPend};

  // highest level wins, lowest index breaks ties (strict compare)
  always_comb begin
    arbValid = 1'b0;
    arbPrio  = '0;
    arbIdx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pendAll[i] && (!arbValid || prioTab[i] > arbPrio)) begin
        arbValid = 1'b1;
        arbPrio  = prioTab[i];
        arbIdx   = IDX_W'(i);
      end
    end
  end

  // stage 2: arbitration result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winValid <= 1'b0;
      winPrio  <= '0;
      winIdx   <= '0;
    end else begin
      winValid <= arbValid;
      winPrio  <= arbPrio;
      winIdx   <= arbIdx;
    end
  end

  // running level after this edge; acknowledge has precedence
  always_comb begin
    curPrioNext = curPrio;
    if (strobes.push)                   curPrioNext = irqPrio;
    else if (strobes.pop && !lifoEmpty) curPrioNext = lifoTop;
    else if (strobes.wrCur)             curPrioNext = regWrData[PRIO_W-1:0];
  end

  // stage 3: request and vector toward the processor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      irqPrio <= '0;
      vecOut  <= '0;
      curPrio <= '0;
    end else begin
      irqOut  <= winValid && (winPrio > curPrioNext);
      irqPrio <= winPrio;
      vecOut  <= VEC_W'(winIdx);
      curPrio <= curPrioNext;
    end
  end

  irq_prio_lifo #(.DEPTH(LIFO_DEPTH), .W(PRIO_W)) uLifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.push),
    .pop    (strobes.pop),
    .din    (curPrio),
    .clrOvf (strobes.wrSts & regWrData[0]),
    .clrUnf (strobes.wrSts & regWrData[1]),
    .top    (lifoTop),
    .empty  (lifoEmpty),
    .ovf    (ovfFlag),
    .unf    (unfFlag)
  );

  always_comb begin
    regRdData = '0;
    case (int'(regAddr))
      REG_CTL: regRdData[0] = hwVecMode;
      REG_CUR: regRdData[PRIO_W-1:0] = curPrio;
      REG_VEC: begin
        regRdData[DATA_W-1]  = irqOut;
        regRdData[VEC_W-1:0] = vecOut;
      end
      REG_SWR: regRdData[NUM_SW-1:0] = swPend;
      REG_STS: regRdData[1:0] = {unfFlag, ovfFlag};
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (int'(regAddr) == REG_PRIO_BASE + i) regRdData[PRIO_W-1:0] = prioTab[i];
      end
    endcase
  end

  assert_irq_above_cur_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqPrio > curPrio);
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> int'(vecOut) < NSRC);
  assert_ack_loads_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> curPrio == $past(irqPrio));
  assert_eoi_restore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && !lifoEmpty) |=> curPrio == $past(lifoTop));
  assert_underflow_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && lifoEmpty) |=> (curPrio == $past(curPrio)) && unfFlag);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_HW     = 16,
  parameter int VEC_W      = 9,
  parameter int LIFO_DEPTH = 16,
  parameter int ADDR_W     = $clog2(REG_PRIO_BASE + NUM_SW + NUM_HW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_HW-1:0] hwReq,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              ackIn,
  output logic              irqOut,
  output logic [VEC_W-1:0]  vecOut
);
  localparam int NSRC = NUM_SW + NUM_HW;

  ctrlStrobes_t strobes;
  logic         hwVecMode;

  irq_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) uCtrl (
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .ackIn     (ackIn),
    .irqOut    (irqOut),
    .hwVecMode (hwVecMode),
    .strobes   (strobes)
  );

  irq_datapath #(
    .NUM_HW(NUM_HW), .VEC_W(VEC_W), .LIFO_DEPTH(LIFO_DEPTH), .ADDR_W(ADDR_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hwReq     (hwReq),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .hwVecMode (hwVecMode),
    .irqOut    (irqOut),
    .vecOut    (vecOut)
  );
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int NUM_HW = 16;
  localparam int NSRC = 8 + NUM_HW;
  localparam int A_CTL = 0, A_CUR = 1, A_VEC = 2, A_EOI = 3, A_SWR = 4, A_STS = 5, A_PRIO = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_HW-1:0] hwReq = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, ackIn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic irqOut;
  logic [8:0] vecOut;

  int nChk = 0, nFail = 0;
  int bPrio [NSRC];
  logic [7:0] swBits = '0;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ackIn(ackIn), .irqOut(irqOut), .vecOut(vecOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'(a); regWrData = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 5'(a);
    #1 d = int'(regRdData);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
  endtask

  task automatic setPrio(input int i, input int p);
    wr(A_PRIO + i, p);
    bPrio[i] = p;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected winner from the requirements
  function automatic void model(input logic [NSRC-1:0] pend, input int cur,
                                output bit v, output int idx, output int pr);
    v = 0; idx = 0; pr = 0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && (!v || bPrio[i] > pr)) begin v = 1; idx = i; pr = bPrio[i]; end
    v = v && (pr > cur);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    int d;
    bit ev; int eIdx, ePr;
    void'($urandom(32'd4021));
    for (int i = 0; i < NSRC; i++) bPrio[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut", int'(irqOut), 0);
    rd(A_CUR, d); chk("R1 cur", d, 0);
    rd(A_CTL, d); chk("R1 mode", d, 1);
    rd(A_STS, d); chk("R1 status", d, 0);
    rd(A_PRIO + 5, d); chk("R1 level", d, 0);

    // R2 level readback
    for (int i = 0; i < NSRC; i++) setPrio(i, (i * 7 + 3) % 16);
    for (int i = 0; i < NSRC; i++) begin rd(A_PRIO + i, d); chk("R2 level", d, (i * 7 + 3) % 16); end
    for (int i = 0; i < NSRC; i++) setPrio(i, 0);

    // R5 latency: hw input 2 -> vector 10
    setPrio(10, 5);
    @(negedge clk); hwReq[2] = 1'b1;
    @(negedge clk); chk("R5 after edge1", int'(irqOut), 0);
    @(negedge clk); chk("R5 after edge2", int'(irqOut), 0);
    @(negedge clk); chk("R5 after edge3", int'(irqOut), 1);
    chk("R3 vector hw", int'(vecOut), 10);

    // R6 acknowledge
    ack();
    chk("R6 irq dropped", int'(irqOut), 0);
    rd(A_CUR, d); chk("R6 cur loaded", d, 5);

    // R3 strictly above
    setPrio(3, 5);
    wr(A_SWR, 16'h0008); swBits = 8'h08;
    waitN(4); chk("R3 equal level held off", int'(irqOut), 0);
    setPrio(3, 6);
    waitN(4); chk("R3 above raises", int'(irqOut), 1);
    chk("R3 vector sw", int'(vecOut), 3);
    ack(); rd(A_CUR, d); chk("R6 nested cur", d, 6);
    wr(A_EOI, 0); rd(A_CUR, d); chk("R7 pop one", d, 5);
    wr(A_EOI, 0); rd(A_CUR, d); chk("R7 pop two", d, 0);
    waitN(3); chk("R7 irq again", int'(irqOut), 1);

    // R4 tie
    setPrio(10, 6);
    waitN(4); chk("R4 tie lowest", int'(vecOut), 3);
    wr(A_SWR, 16'h0800); swBits = 8'h00;
    waitN(4); chk("R4 other wins", int'(vecOut), 10);

    // R8 ceiling
    wr(A_CUR, 6); waitN(2); chk("R8 ceiling masks", int'(irqOut), 0);
    wr(A_CUR, 5); waitN(2); chk("R8 lower releases", int'(irqOut), 1);
    wr(A_CUR, 0);

    // R12 stray ack
    hwReq = '0; waitN(5);
    chk("R12 idle", int'(irqOut), 0);
    ack(); rd(A_CUR, d); chk("R12 stray ack ignored", d, 0);

    // R9 software sources
    wr(A_SWR, 16'h0081); rd(A_SWR, d); chk("R9 set", d, 8'h81);
    wr(A_SWR, 16'h0100); rd(A_SWR, d); chk("R9 clear", d, 8'h80);
    wr(A_SWR, 16'h4040); rd(A_SWR, d); chk("R9 clear wins", d, 8'h80);

    // R10 software vector mode, source 7 at level 9
    setPrio(7, 9);
    wr(A_CTL, 0); waitN(4);
    ack(); rd(A_CUR, d); chk("R12 ack ignored in sw mode", d, 0);
    rd(A_VEC, d); chk("R10 vector read", d, 16'h8007);
    rd(A_CUR, d); chk("R10 read acks", d, 9);
    wr(A_CTL, 1); wr(A_EOI, 0); waitN(3);
    rd(A_VEC, d); chk("R10 hw-mode read", d, 16'h8007);
    rd(A_CUR, d); chk("R10 hw-mode read no ack", d, 0);

    // R11 overflow and underflow
    for (int k = 0; k < 17; k++) begin
      waitN(3); ack(); wr(A_CUR, 0);
      if (k == 15) begin rd(A_STS, d); chk("R11 16 fit", d, 0); end
    end
    rd(A_STS, d); chk("R11 overflow", d, 1);
    wr(A_STS, 1); rd(A_STS, d); chk("R11 clear ovf", d, 0);
    for (int k = 0; k < 16; k++) wr(A_EOI, 0);
    rd(A_STS, d); chk("R11 no underflow yet", d, 0);
    wr(A_CUR, 3); wr(A_EOI, 0);
    rd(A_STS, d); chk("R11 underflow", d, 2);
    rd(A_CUR, d); chk("R11 cur kept", d, 3);
    wr(A_STS, 2); wr(A_CUR, 0);
    wr(A_SWR, 16'hFF00); swBits = '0;

    // randomized patterns against the model (R3 R4 R6 R7)
    for (int it = 0; it < 150; it++) begin
      logic [NUM_HW-1:0] hwBits;
      int cur;
      for (int i = 0; i < NSRC; i++) setPrio(i, int'($urandom % 16));
      hwBits = NUM_HW'($urandom);
      swBits = 8'($urandom);
      cur = int'($urandom % 8);
      @(negedge clk); hwReq = hwBits;
      wr(A_SWR, {~swBits, swBits});
      wr(A_CUR, cur);
      waitN(4);
      model({hwBits, swBits}, cur, ev, eIdx, ePr);
      chk("R3 random irq", int'(irqOut), int'(ev));
      if (ev) begin
        chk("R4 random vector", int'(vecOut), eIdx);
        ack(); rd(A_CUR, d); chk("R6 random ack", d, ePr);
        wr(A_EOI, 0); rd(A_CUR, d); chk("R7 random restore", d, cur);
      end
      wr(A_CUR, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule